// File: doc/BRIEF.md
# LUN Command Dispatcher

This block sits behind the step that turns an extension identifier into a logical unit number (LUN). It receives a command: a first operand whose top 12 bits carry the LUN, a second operand, a command number and the privilege level of the issuer. A 16-entry mapping table, keyed on the pair (LUN, privilege), names the target. The target is either an external device, identified by a device select and an interface id, or a built-in fallback unit that answers without leaving the block.

Commands for an external device go out on a valid/ready request port and come back on a response strobe with a 64-bit word. Commands for the fallback unit finish one cycle after acceptance. When no entry matches, the block issues no request. Instead it raises a trap aimed one privilege level above the issuer. Only one command is in flight at a time. Table entries are loaded through a write-only configuration port.

Top module: `lun_cmd_dispatch`

## Requirements
- R1: After reset `cmd_ready` is 1 and `res_valid`, `trap_valid` and `dev_req_valid` are 0. Every table entry is invalid, so the first command traps.
- R2: The lookup key is the LUN `cmd_op1[63:52]` together with `cmd_priv`. A matching device entry raises `dev_req_valid` one cycle after acceptance. The request carries the entry's device select and interface id, plus the command number, both operands and the privilege, all unchanged.
- R3: A command whose LUN is 0 never matches any entry, even one written with LUN 0, so it always traps with cause 0.
- R4: A command with no matching entry pulses `trap_valid` for one cycle, one cycle after acceptance, with `trap_cause` 0 (unmapped). `trap_priv` is the issuer level plus one, saturating at 3 (levels 0 user, 1 supervisor, 2 hypervisor, 3 machine). No device request is raised.
- R5: When several valid entries match, the one with the lowest index decides.
- R6: A matching fallback entry computes a selector, which is (interface id − 1) modulo 4096. Selector 0 gives `res_valid` with data 0 one cycle after acceptance. Selector 1 gives all ones. So interface 1 returns zero and interface 2 returns −1.
- R7: Any other fallback selector (for example interface 0 or 3) pulses `trap_valid` one cycle after acceptance, with `trap_cause` 1 (configuration error) and the same next-higher `trap_priv`. No result is produced.
- R8: The privilege level is part of the key. The same LUN can reach interface 64 at machine level and interface 0 at user level.
- R9: Each request follows the same sequence.
  - While `dev_req_valid` is 1 and `dev_req_ready` is 0, the request and all its fields stay unchanged, and a response strobe in that period is ignored.
  - `cmd_ready` stays 0 from acceptance until the response.
  - The response strobe is taken only after the request transfer. One cycle later `res_valid` is 1 with `res_data` equal to `dev_rsp_data`, and `cmd_ready` is 1 again.
- R10: A configuration write with `cfg_valid` 0 removes an entry. Lookups then fall to the next matching index, or trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | 4 | Entry index to write |
| cfg_valid | input | 1 | Valid bit written to the entry |
| cfg_lun | input | 12 | LUN of the entry |
| cfg_priv | input | 2 | Privilege level of the entry |
| cfg_fallback | input | 1 | Entry targets the built-in fallback unit |
| cfg_dev | input | 3 | Device select of the entry |
| cfg_ifc | input | 12 | Interface id of the entry |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command taken when valid |
| cmd_op1 | input | 64 | Packed LUN (top 12 bits) and data |
| cmd_op2 | input | 64 | Second operand |
| cmd_num | input | 12 | Command number |
| cmd_priv | input | 2 | Issuer privilege level |
| dev_req_valid | output | 1 | Device request valid |
| dev_req_ready | input | 1 | Device accepts request |
| dev_sel | output | 3 | Target device select |
| dev_ifc | output | 12 | Target interface id |
| dev_cmd | output | 12 | Forwarded command number |
| dev_op1 | output | 64 | Forwarded first operand |
| dev_op2 | output | 64 | Forwarded second operand |
| dev_priv | output | 2 | Forwarded privilege level |
| dev_rsp_valid | input | 1 | Device response strobe |
| dev_rsp_data | input | 64 | Device response word |
| res_valid | output | 1 | Result pulse |
| res_data | output | 64 | Result word |
| trap_valid | output | 1 | Trap request pulse |
| trap_cause | output | 1 | 0 unmapped, 1 configuration error |
| trap_priv | output | 2 | Privilege level the trap targets |

## Verification
The assertions assume the device obeys the handshake. It must raise `dev_rsp_valid` for exactly one cycle per transferred request, and only after the transfer, so that a strobe seen in the waiting state truly belongs to the outstanding command. A strobe during the request phase is allowed and must be dropped. The stimulus enforces this with a device model that answers each request once, after a random delay. It occasionally injects a stray strobe before the transfer. It also holds `cmd_valid` for a single accepted cycle, so no second command is offered while one is open.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

  typedef enum logic [0:0] {
    TRAP_UNMAPPED = 1'b0,
    TRAP_CFG_ERR  = 1'b1
  } trap_cause_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } ctrl_state_e;

  localparam logic [1:0] PRIV_TOP = 2'd3;

  // Trap target: one level above the issuer, machine level traps to itself.
  function automatic logic [1:0] next_priv(input logic [1:0] p);
    return (p == PRIV_TOP) ? PRIV_TOP : p + 2'd1;
  endfunction

endpackage

// File: rtl/lcd_map_table.sv
module lcd_map_table #(
  parameter int ENTRIES = 16,
  parameter int LUN_W   = 12,
  parameter int DEV_W   = 3,
  parameter int IFC_W   = 12,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic [LUN_W-1:0] wr_lun,
  input  logic [1:0]       wr_priv,
  input  logic             wr_fb,
  input  logic [DEV_W-1:0] wr_dev,
  input  logic [IFC_W-1:0] wr_ifc,
  input  logic [LUN_W-1:0] key_lun,
  input  logic [1:0]       key_priv,
  output logic             hit,
  output logic             hit_fb,
  output logic [DEV_W-1:0] hit_dev,
  output logic [IFC_W-1:0] hit_ifc
);

  logic [ENTRIES-1:0] vld_q;
  logic [ENTRIES-1:0] match;
  logic [LUN_W-1:0]   lun_q  [ENTRIES];
  logic [1:0]         priv_q [ENTRIES];
  logic               fb_q   [ENTRIES];
  logic [DEV_W-1:0]   dev_q  [ENTRIES];
  logic [IFC_W-1:0]   ifc_q  [ENTRIES];

  // LUN 0 is reserved: it never resolves, whatever was written.
  logic key_ok;
  assign key_ok = (key_lun != '0);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    logic sel_en;
    assign sel_en = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      vld_q[g] <= 1'b0;
      else if (sel_en) vld_q[g] <= wr_valid;
    end

    always_ff @(posedge clk) begin
      if (sel_en) begin
        lun_q[g]  <= wr_lun;
        priv_q[g] <= wr_priv;
        fb_q[g]   <= wr_fb;
        dev_q[g]  <= wr_dev;
        ifc_q[g]  <= wr_ifc;
      end
    end

    assign match[g] = vld_q[g] && key_ok &&
                      (lun_q[g] == key_lun) && (priv_q[g] == key_priv);
  end

  // Priority select: scanning downward leaves the lowest matching index.
  always_comb begin
    hit     = 1'b0;
    hit_fb  = 1'b0;
    hit_dev = '0;
    hit_ifc = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit     = 1'b1;
        hit_fb  = fb_q[i];
        hit_dev = dev_q[i];
        hit_ifc = ifc_q[i];
      end
    end
  end

  // R5: at most one winner is reported, and only when some entry matches.
  p_hit_has_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (match != '0));

endmodule

// File: rtl/lcd_fallback.sv
module lcd_fallback #(
  parameter int XLEN  = 64,
  parameter int IFC_W = 12
) (
  input  logic [IFC_W-1:0] ifc,
  output logic             ok,
  output logic [XLEN-1:0]  data
);

  // Selector is (interface id - 1) wrapped to the id width.
  localparam logic [IFC_W-1:0] SEL_ZERO = IFC_W'(0);
  localparam logic [IFC_W-1:0] SEL_ONES = IFC_W'(1);

  logic [IFC_W-1:0] sel;
  assign sel = ifc - IFC_W'(1);

  always_comb begin
    ok   = 1'b0;
    data = '0;
    if (sel == SEL_ZERO) begin
      ok   = 1'b1;
      data = '0;
    end else if (sel == SEL_ONES) begin
      ok   = 1'b1;
      data = '1;
    end
  end

  // R6: the minus-one answer is only ever given for selector 1.
  always_comb begin
    if (ok && (data != '0)) begin
      a_ones_only_sel1_r6: assert (sel == SEL_ONES);
    end
  end

endmodule

// File: rtl/lcd_ctrl.sv
module lcd_ctrl
  import lcd_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int LUN_W = 12,
  parameter int DEV_W = 3,
  parameter int IFC_W = 12,
  parameter int CMD_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [LUN_W-1:0] cmd_lun,
  input  logic [XLEN-1:0]  cmd_op1,
  input  logic [XLEN-1:0]  cmd_op2,
  input  logic [CMD_W-1:0] cmd_num,
  input  logic [1:0]       cmd_priv,
  input  logic             hit,
  input  logic             hit_fb,
  input  logic [DEV_W-1:0] hit_dev,
  input  logic [IFC_W-1:0] hit_ifc,
  input  logic             fb_ok,
  input  logic [XLEN-1:0]  fb_data,
  output logic             dev_req_valid,
  input  logic             dev_req_ready,
  output logic [DEV_W-1:0] dev_sel,
  output logic [IFC_W-1:0] dev_ifc,
  output logic [CMD_W-1:0] dev_cmd,
  output logic [XLEN-1:0]  dev_op1,
  output logic [XLEN-1:0]  dev_op2,
  output logic [1:0]       dev_priv,
  input  logic             dev_rsp_valid,
  input  logic [XLEN-1:0]  dev_rsp_data,
  output logic             res_valid,
  output logic [XLEN-1:0]  res_data,
  output logic             trap_valid,
  output logic             trap_cause,
  output logic [1:0]       trap_priv
);

  ctrl_state_e state_q, state_d;
  logic              res_valid_q, res_valid_d;
  logic [XLEN-1:0]   res_data_q, res_data_d;
  logic              res_en;
  logic              trap_valid_q, trap_valid_d;
  trap_cause_e       trap_cause_q, trap_cause_d;
  logic [1:0]        trap_priv_q;
  logic              trap_en;
  logic              req_en;
  logic [DEV_W-1:0]  sel_q;
  logic [IFC_W-1:0]  ifc_q;
  logic [CMD_W-1:0]  num_q;
  logic [XLEN-1:0]   op1_q, op2_q;
  logic [1:0]        priv_q;
  logic              accept;

  assign cmd_ready = (state_q == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;

  // Next-state and output-next logic.
  always_comb begin
    state_d      = state_q;
    req_en       = 1'b0;
    res_en       = 1'b0;
    res_valid_d  = 1'b0;
    res_data_d   = res_data_q;
    trap_en      = 1'b0;
    trap_valid_d = 1'b0;
    trap_cause_d = trap_cause_q;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          if (!hit) begin
            trap_en      = 1'b1;
            trap_valid_d = 1'b1;
            trap_cause_d = TRAP_UNMAPPED;
          end else if (hit_fb) begin
            if (fb_ok) begin
              res_en      = 1'b1;
              res_valid_d = 1'b1;
              res_data_d  = fb_data;
            end else begin
              trap_en      = 1'b1;
              trap_valid_d = 1'b1;
              trap_cause_d = TRAP_CFG_ERR;
            end
          end else begin
            req_en  = 1'b1;
            state_d = ST_REQ;
          end
        end
      end
      ST_REQ: begin
        if (dev_req_ready) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (dev_rsp_valid) begin
          res_en      = 1'b1;
          res_valid_d = 1'b1;
          res_data_d  = dev_rsp_data;
          state_d     = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Control registers with asynchronous reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      res_valid_q  <= 1'b0;
      trap_valid_q <= 1'b0;
    end else begin
      state_q      <= state_d;
      res_valid_q  <= res_valid_d;
      trap_valid_q <= trap_valid_d;
    end
  end

  // Data registers, enabled only when they take a new value.
  always_ff @(posedge clk) begin
    if (res_en) res_data_q <= res_data_d;
    if (trap_en) begin
      trap_cause_q <= trap_cause_d;
      trap_priv_q  <= next_priv(cmd_priv);
    end
    if (req_en) begin
      sel_q  <= hit_dev;
      ifc_q  <= hit_ifc;
      num_q  <= cmd_num;
      op1_q  <= cmd_op1;
      op2_q  <= cmd_op2;
      priv_q <= cmd_priv;
    end
  end

  assign dev_req_valid = (state_q == ST_REQ);
  assign dev_sel       = sel_q;
  assign dev_ifc       = ifc_q;
  assign dev_cmd       = num_q;
  assign dev_op1       = op1_q;
  assign dev_op2       = op2_q;
  assign dev_priv      = priv_q;
  assign res_valid     = res_valid_q;
  assign res_data      = res_data_q;
  assign trap_valid    = trap_valid_q;
  assign trap_cause    = trap_cause_q;
  assign trap_priv     = trap_priv_q;

  p_lun0_traps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_lun == '0) |=> (trap_valid && !dev_req_valid && !res_valid));

  p_miss_no_request_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !hit) |=> (trap_valid && trap_cause == TRAP_UNMAPPED && !dev_req_valid));

  p_trap_goes_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> (trap_priv != 2'd0));

  p_fallback_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hit && hit_fb) |=> (res_valid != trap_valid) && !dev_req_valid);

  p_single_outcome_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && trap_valid));

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_req_valid && !dev_req_ready) |=>
      (dev_req_valid && $stable(dev_sel) && $stable(dev_ifc) && $stable(dev_cmd) &&
       $stable(dev_op1) && $stable(dev_op2) && $stable(dev_priv)));

  p_busy_while_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_req_valid && dev_req_ready) |=> !cmd_ready && !dev_req_valid);

  p_rsp_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && dev_rsp_valid) |=>
      (res_valid && res_data == $past(dev_rsp_data) && cmd_ready));

endmodule

// File: rtl/lun_cmd_dispatch.sv
module lun_cmd_dispatch #(
  parameter int XLEN    = 64,
  parameter int LUN_W   = 12,
  parameter int ENTRIES = 16,
  parameter int DEV_W   = 3,
  parameter int IFC_W   = 12,
  parameter int CMD_W   = 12,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic             cfg_valid,
  input  logic [LUN_W-1:0] cfg_lun,
  input  logic [1:0]       cfg_priv,
  input  logic             cfg_fallback,
  input  logic [DEV_W-1:0] cfg_dev,
  input  logic [IFC_W-1:0] cfg_ifc,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [XLEN-1:0]  cmd_op1,
  input  logic [XLEN-1:0]  cmd_op2,
  input  logic [CMD_W-1:0] cmd_num,
  input  logic [1:0]       cmd_priv,
  output logic             dev_req_valid,
  input  logic             dev_req_ready,
  output logic [DEV_W-1:0] dev_sel,
  output logic [IFC_W-1:0] dev_ifc,
  output logic [CMD_W-1:0] dev_cmd,
  output logic [XLEN-1:0]  dev_op1,
  output logic [XLEN-1:0]  dev_op2,
  output logic [1:0]       dev_priv,
  input  logic             dev_rsp_valid,
  input  logic [XLEN-1:0]  dev_rsp_data,
  output logic             res_valid,
  output logic [XLEN-1:0]  res_data,
  output logic             trap_valid,
  output logic             trap_cause,
  output logic [1:0]       trap_priv
);

  logic [LUN_W-1:0] key_lun;
  logic             hit, hit_fb, fb_ok;
  logic [DEV_W-1:0] hit_dev;
  logic [IFC_W-1:0] hit_ifc;
  logic [XLEN-1:0]  fb_data;

  assign key_lun = cmd_op1[XLEN-1 -: LUN_W];

  lcd_map_table #(
    .ENTRIES(ENTRIES), .LUN_W(LUN_W), .DEV_W(DEV_W), .IFC_W(IFC_W)
  ) i_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_valid(cfg_valid), .wr_lun(cfg_lun),
    .wr_priv(cfg_priv), .wr_fb(cfg_fallback), .wr_dev(cfg_dev), .wr_ifc(cfg_ifc),
    .key_lun(key_lun), .key_priv(cmd_priv),
    .hit(hit), .hit_fb(hit_fb), .hit_dev(hit_dev), .hit_ifc(hit_ifc)
  );

  lcd_fallback #(.XLEN(XLEN), .IFC_W(IFC_W)) i_fallback (
    .ifc(hit_ifc), .ok(fb_ok), .data(fb_data)
  );

  lcd_ctrl #(
    .XLEN(XLEN), .LUN_W(LUN_W), .DEV_W(DEV_W), .IFC_W(IFC_W), .CMD_W(CMD_W)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_lun(key_lun),
    .cmd_op1(cmd_op1), .cmd_op2(cmd_op2), .cmd_num(cmd_num), .cmd_priv(cmd_priv),
    .hit(hit), .hit_fb(hit_fb), .hit_dev(hit_dev), .hit_ifc(hit_ifc),
    .fb_ok(fb_ok), .fb_data(fb_data),
    .dev_req_valid(dev_req_valid), .dev_req_ready(dev_req_ready),
    .dev_sel(dev_sel), .dev_ifc(dev_ifc), .dev_cmd(dev_cmd),
    .dev_op1(dev_op1), .dev_op2(dev_op2), .dev_priv(dev_priv),
    .dev_rsp_valid(dev_rsp_valid), .dev_rsp_data(dev_rsp_data),
    .res_valid(res_valid), .res_data(res_data),
    .trap_valid(trap_valid), .trap_cause(trap_cause), .trap_priv(trap_priv)
  );

endmodule

// File: tb/test_lun_cmd_dispatch.sv
module test_lun_cmd_dispatch;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_valid, cfg_fallback;
  logic [3:0]  cfg_idx;
  logic [11:0] cfg_lun, cfg_ifc;
  logic [1:0]  cfg_priv;
  logic [2:0]  cfg_dev;
  logic        cmd_valid, cmd_ready;
  logic [63:0] cmd_op1, cmd_op2;
  logic [11:0] cmd_num;
  logic [1:0]  cmd_priv;
  logic        dev_req_valid, dev_req_ready;
  logic [2:0]  dev_sel;
  logic [11:0] dev_ifc, dev_cmd;
  logic [63:0] dev_op1, dev_op2;
  logic [1:0]  dev_priv;
  logic        dev_rsp_valid;
  logic [63:0] dev_rsp_data;
  logic        res_valid, trap_valid, trap_cause;
  logic [63:0] res_data;
  logic [1:0]  trap_priv;

  int vectors = 0;
  int errors  = 0;

  // Shadow of the mapping table.
  bit          sh_v   [16];
  logic [11:0] sh_lun [16];
  logic [1:0]  sh_prv [16];
  bit          sh_fb  [16];
  logic [2:0]  sh_dev [16];
  logic [11:0] sh_ifc [16];

  always #5 clk = ~clk;

  lun_cmd_dispatch i_lun_cmd_dispatch (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid), .cfg_lun(cfg_lun),
    .cfg_priv(cfg_priv), .cfg_fallback(cfg_fallback), .cfg_dev(cfg_dev), .cfg_ifc(cfg_ifc),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op1(cmd_op1), .cmd_op2(cmd_op2),
    .cmd_num(cmd_num), .cmd_priv(cmd_priv),
    .dev_req_valid(dev_req_valid), .dev_req_ready(dev_req_ready), .dev_sel(dev_sel),
    .dev_ifc(dev_ifc), .dev_cmd(dev_cmd), .dev_op1(dev_op1), .dev_op2(dev_op2),
    .dev_priv(dev_priv), .dev_rsp_valid(dev_rsp_valid), .dev_rsp_data(dev_rsp_data),
    .res_valid(res_valid), .res_data(res_data), .trap_valid(trap_valid),
    .trap_cause(trap_cause), .trap_priv(trap_priv)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int lookup(input logic [11:0] lun, input logic [1:0] prv);
    if (lun == 12'd0) return -1;
    for (int i = 0; i < 16; i++)
      if (sh_v[i] && sh_lun[i] == lun && sh_prv[i] == prv) return i;
    return -1;
  endfunction

  function automatic logic [1:0] up_priv(input logic [1:0] p);
    return (p == 2'd3) ? 2'd3 : p + 2'd1;
  endfunction

  task automatic cfg_write(input int idx, input bit v, input logic [11:0] lun,
                           input logic [1:0] prv, input bit fb, input logic [2:0] dev,
                           input logic [11:0] ifc);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_valid = v; cfg_lun = lun;
    cfg_priv = prv; cfg_fallback = fb; cfg_dev = dev; cfg_ifc = ifc;
    @(negedge clk);
    cfg_we = 1'b0;
    sh_v[idx] = v; sh_lun[idx] = lun; sh_prv[idx] = prv;
    sh_fb[idx] = fb; sh_dev[idx] = dev; sh_ifc[idx] = ifc;
  endtask

  task automatic run_cmd(input logic [11:0] lun, input logic [1:0] prv,
                         input int hold, input bit poke, input string tag);
    logic [63:0] op1, op2, rsp;
    logic [11:0] num;
    logic [11:0] sel;
    int idx;
    op1 = {lun, 20'($urandom), $urandom};
    op2 = {$urandom, $urandom};
    num = 12'($urandom);
    idx = lookup(lun, prv);
    @(negedge clk);
    check(cmd_ready == 1'b1, {tag, " R9 ready before command"}, 64'(cmd_ready), 64'd1);
    cmd_valid = 1'b1; cmd_op1 = op1; cmd_op2 = op2; cmd_num = num; cmd_priv = prv;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (idx < 0) begin
      check(trap_valid && !res_valid && !dev_req_valid && trap_cause == 1'b0,
            {tag, (lun == 0) ? " R3 lun0 trap" : " R4 unmapped trap"},
            {60'd0, trap_valid, res_valid, dev_req_valid, trap_cause}, 64'h8);
      check(trap_priv == up_priv(prv), {tag, " R4 trap level"}, 64'(trap_priv),
            64'(up_priv(prv)));
    end else if (sh_fb[idx]) begin
      sel = sh_ifc[idx] - 12'd1;
      if (sel < 12'd2) begin
        check(res_valid && !trap_valid && !dev_req_valid, {tag, " R6 fallback result valid"},
              {61'd0, res_valid, trap_valid, dev_req_valid}, 64'h4);
        check(res_data == ((sel == 12'd1) ? '1 : 64'd0), {tag, " R6 fallback data"},
              res_data, (sel == 12'd1) ? '1 : 64'd0);
      end else begin
        check(trap_valid && !res_valid && trap_cause == 1'b1, {tag, " R7 config error trap"},
              {61'd0, trap_valid, res_valid, trap_cause}, 64'h5);
        check(trap_priv == up_priv(prv), {tag, " R7 trap level"}, 64'(trap_priv),
              64'(up_priv(prv)));
      end
    end else begin
      check(dev_req_valid && !trap_valid && !res_valid, {tag, " R2 request raised"},
            {61'd0, dev_req_valid, trap_valid, res_valid}, 64'h4);
      check(dev_sel == sh_dev[idx] && dev_ifc == sh_ifc[idx], {tag, " R2 R5 R8 target"},
            {49'd0, dev_sel, dev_ifc}, {49'd0, sh_dev[idx], sh_ifc[idx]});
      check(dev_op1 == op1 && dev_op2 == op2 && dev_cmd == num && dev_priv == prv,
            {tag, " R2 forwarded fields"}, dev_op1 ^ op1, 64'd0);
      check(cmd_ready == 1'b0, {tag, " R9 busy"}, 64'(cmd_ready), 64'd0);
      for (int k = 0; k < hold; k++) @(negedge clk);
      if (poke) begin
        dev_rsp_valid = 1'b1; dev_rsp_data = 64'hDEAD_0000_BEEF_0000;
        @(negedge clk);
        dev_rsp_valid = 1'b0;
        check(!res_valid && dev_req_valid && dev_ifc == sh_ifc[idx] && dev_op2 == op2,
              {tag, " R9 early strobe ignored, request held"},
              {62'd0, res_valid, dev_req_valid}, 64'h1);
      end
      dev_req_ready = 1'b1;
      @(negedge clk);
      dev_req_ready = 1'b0;
      check(!dev_req_valid && !cmd_ready, {tag, " R9 waiting for response"},
            {62'd0, dev_req_valid, cmd_ready}, 64'd0);
      rsp = {$urandom, $urandom};
      dev_rsp_valid = 1'b1; dev_rsp_data = rsp;
      @(negedge clk);
      dev_rsp_valid = 1'b0;
      check(res_valid && res_data == rsp && cmd_ready, {tag, " R9 response returned"},
            res_data, rsp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog expired: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    cfg_we = 1'b0; cfg_idx = '0; cfg_valid = 1'b0; cfg_lun = '0; cfg_priv = '0;
    cfg_fallback = 1'b0; cfg_dev = '0; cfg_ifc = '0;
    cmd_valid = 1'b0; cmd_op1 = '0; cmd_op2 = '0; cmd_num = '0; cmd_priv = '0;
    dev_req_ready = 1'b0; dev_rsp_valid = 1'b0; dev_rsp_data = '0;
    for (int i = 0; i < 16; i++) sh_v[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready && !res_valid && !trap_valid && !dev_req_valid, "R1 reset outputs",
          {60'd0, cmd_ready, res_valid, trap_valid, dev_req_valid}, 64'h8);
    run_cmd(12'd1, 2'd0, 0, 0, "R1 empty table");

    // Directed table contents.
    for (int p = 0; p < 4; p++) begin
      cfg_write(2 + p, 1, 12'd1, 2'(p), 1, 3'd0, 12'd1);
      cfg_write(6 + p, 1, 12'd2, 2'(p), 1, 3'd0, 12'd2);
    end
    cfg_write(10, 1, 12'd32, 2'd3, 0, 3'd1, 12'd64);
    cfg_write(11, 1, 12'd32, 2'd0, 0, 3'd1, 12'd0);
    cfg_write(12, 1, 12'd0,  2'd0, 0, 3'd2, 12'd5);
    cfg_write(13, 1, 12'd7,  2'd1, 1, 3'd0, 12'd3);
    cfg_write(14, 1, 12'd40, 2'd2, 1, 3'd0, 12'd0);
    cfg_write(0,  1, 12'd33, 2'd1, 0, 3'd3, 12'd1);
    cfg_write(1,  1, 12'd33, 2'd1, 0, 3'd4, 12'd9);

    for (int p = 0; p < 4; p++) begin
      run_cmd(12'd1, 2'(p), 0, 0, "R6 return zero");
      run_cmd(12'd2, 2'(p), 0, 0, "R6 return minus one");
    end
    run_cmd(12'd32, 2'd3, 2, 0, "R8 machine interface");
    run_cmd(12'd32, 2'd0, 0, 1, "R8 user interface");
    run_cmd(12'd32, 2'd1, 0, 0, "R4 level without entry");
    run_cmd(12'd0,  2'd0, 0, 0, "R3 lun zero");
    run_cmd(12'd7,  2'd1, 0, 0, "R7 selector two");
    run_cmd(12'd40, 2'd2, 0, 0, "R7 interface zero");
    run_cmd(12'd33, 2'd1, 1, 1, "R5 lowest index");
    run_cmd(12'd99, 2'd3, 0, 0, "R4 machine saturates");
    cfg_write(0, 0, 12'd33, 2'd1, 0, 3'd3, 12'd1);
    run_cmd(12'd33, 2'd1, 0, 0, "R10 removed falls through");
    cfg_write(1, 0, 12'd33, 2'd1, 0, 3'd4, 12'd9);
    run_cmd(12'd33, 2'd1, 0, 0, "R10 removed traps");

    // Random mix of table writes and commands.
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 3) == 0) begin
        logic [11:0] rifc;
        case ($urandom_range(0, 5))
          0: rifc = 12'd0;
          1: rifc = 12'd1;
          2: rifc = 12'd2;
          3: rifc = 12'd3;
          4: rifc = 12'd64;
          default: rifc = 12'($urandom);
        endcase
        cfg_write($urandom_range(0, 15), $urandom_range(0, 4) != 0,
                  12'($urandom_range(0, 5)), 2'($urandom), $urandom_range(0, 1) == 1,
                  3'($urandom), rifc);
      end else begin
        run_cmd(12'($urandom_range(0, 5)), 2'($urandom), $urandom_range(0, 3),
                $urandom_range(0, 3) == 0, "R2 random");
      end
    end

    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule